// File: doc/BRIEF.md
# Atomic Multi-Channel Weight Committer

This block moves new amplitude and phase control words from a host staging area into a group of channel endpoints. The new words take effect on every channel at once, or on none of them. The host first fills a staging register for each channel, then starts a transaction and names the channels it targets with a mask. Writing the staging registers never changes a live weight. The block stamps every payload with a running sequence number and an 8-bit CRC and sends it to each targeted endpoint. It then requires an acknowledgement from each of those endpoints, and a readback of the endpoint's shadow register must match the staged word. Only after all of this does it raise a single latch strobe, and every targeted endpoint copies shadow to active on that strobe.

A transaction can fail for two kinds of reason. The first is a configuration problem: a zero table version or an empty mask. The second is a validation problem: a missing endpoint, a payload rejected for CRC or sequence, or a readback mismatch. In either case the latch is withheld and every active weight keeps its value. After a run of consecutive validation failures the block forces all channels back to the safe default profile. At reset every channel already holds this safe profile, with no bus traffic needed. Three saturating counters record the outcomes. The endpoints are simple register models, and each has fault controls so the failure paths can be exercised.

Top module: `weightCommitter`

## Requirements
- R1: After reset, every channel's active amplitude and phase equal the safe default (0 and 0), all three counters and the sequence number read 0, and busy, latch and abort are low.
- R2: A staging write has no effect on any active output. A staging write is ignored while busy is high.
- R3: A start accepted while idle raises busy for exactly three cycles and increments the sequence number by one. The third busy cycle carries either the latch pulse or the abort pulse, never both.
- R4: On a commit, every targeted channel takes its staged amplitude and phase in the same cycle, and channels outside the mask keep their values.
- R5: If a targeted endpoint gives no response, rejects a corrupted payload (CRC or sequence mismatch), or returns a readback that differs from the staged word, no latch is issued, abort pulses, and all active values stay unchanged.
- R6: A start with table version 0 or an empty mask is skipped. The skip counter increments and the failure counter does not.
- R7: The failure, skip and rollback counters are CNT_W bits wide and saturate at their all-ones value.
- R8: When FAIL_LIMIT validation failures occur with no commit between them, every channel's active value returns to the safe default on the last of them, and the rollback counter increments. A commit clears the run.
- R9: A start asserted while busy is ignored: it does not extend the transaction or change the sequence number.
- R10: Faults injected on channels outside the mask have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stageWe | input | 1 | Staging write enable |
| stageCh | input | CH_W | Channel selected for the staging write |
| stageAmp | input | AMP_W | Staged amplitude code |
| stagePh | input | PH_W | Staged phase code |
| chMask | input | NUM_CH | Targeted channels, sampled at start |
| tableVer | input | VER_W | Table version, where 0 means invalid; sampled at start |
| start | input | 1 | Begin a transaction |
| epDrop | input | NUM_CH | Endpoint model fault: endpoint absent |
| epCorrupt | input | NUM_CH | Endpoint model fault: amplitude bit 0 flipped on the link |
| epRbErr | input | NUM_CH | Endpoint model fault: amplitude bit 0 flipped on readback |
| busy | output | 1 | Transaction in progress |
| latchPulse | output | 1 | Shared commit strobe |
| abortPulse | output | 1 | Transaction skipped |
| seqId | output | SEQ_W | Sequence number of the latest transaction |
| activeAmp | output | NUM_CH*AMP_W | Active amplitudes; channel i at bits [i*AMP_W +: AMP_W] |
| activePh | output | NUM_CH*PH_W | Active phases; channel i at bits [i*PH_W +: PH_W] |
| failCnt | output | CNT_W | Validation failure count |
| skipCnt | output | CNT_W | Skipped latch count |
| rollCnt | output | CNT_W | Rollback count |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a host action and the commit. The bench places a staging write and a held start in the busy cycles, including the latch cycle itself. It judges the result by the value a later commit of that channel exposes and by the sequence number.

The second pair is failure accounting and rollback, which share the edge that ends the last failure of a run. Here the bench counts failures across interleaved skips, and a cycle-by-cycle reference model confirms that the counters and all active weights change together. The same model is run past the saturation point of all three counters.

// File: rtl/wcPkg.sv
package wcPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_CHECK,
    ST_COMMIT,
    ST_ABORT
  } wcState_t;

  typedef struct packed {
    logic capture;
    logic send;
    logic commit;
    logic abort;
    logic failEvt;
    logic rollback;
  } wcStrobe_t;

  localparam int CRC_MSG_MAX = 64;

  function automatic logic [7:0] crc8Bit(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
  endfunction

  function automatic logic [7:0] crc8Msg(input logic [CRC_MSG_MAX-1:0] msg, input int len);
    logic [7:0] c;
    c = 8'h00;
    for (int i = CRC_MSG_MAX - 1; i >= 0; i--) begin
      if (i < len) c = crc8Bit(c, msg[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/wcEndpoint.sv
module wcEndpoint
  import wcPkg::*;
#(
  parameter int CH_ID = 0,
  parameter int AMP_W = 6,
  parameter int PH_W = 6,
  parameter int SEQ_W = 8,
  parameter int CHID_W = 8,
  parameter logic [AMP_W-1:0] SAFE_AMP = '0,
  parameter logic [PH_W-1:0] SAFE_PH = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txnBegin,
  input  logic             payValid,
  input  logic [SEQ_W-1:0] paySeq,
  input  logic [AMP_W-1:0] payAmp,
  input  logic [PH_W-1:0]  payPh,
  input  logic [7:0]       payCrc,
  input  logic             drop,
  input  logic             corrupt,
  input  logic             rbErr,
  input  logic             latchEn,
  input  logic             rollback,
  output logic             rspSeen,
  output logic             rspOk,
  output logic [AMP_W-1:0] rbAmp,
  output logic [PH_W-1:0]  rbPh,
  output logic [AMP_W-1:0] actAmp,
  output logic [PH_W-1:0]  actPh
);

  localparam int MSG_W = CHID_W + SEQ_W + AMP_W + PH_W;

  logic [SEQ_W-1:0] expSeq;
  logic [AMP_W-1:0] shadowAmp;
  logic [PH_W-1:0]  shadowPh;
  logic [AMP_W-1:0] rxAmp;
  logic [7:0]       rxCrc;
  logic             crcGood;
  logic             seqGood;
  logic             accept;

  assign rxAmp   = payAmp ^ AMP_W'(corrupt);
  assign rxCrc   = crc8Msg(CRC_MSG_MAX'({CHID_W'(CH_ID), paySeq, rxAmp, payPh}), MSG_W);
  assign crcGood = (rxCrc == payCrc);
  assign seqGood = (paySeq == expSeq);
  assign accept  = payValid & ~drop & crcGood & seqGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expSeq <= '0;
    end else if (txnBegin) begin
      expSeq <= expSeq + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspSeen   <= 1'b0;
      rspOk     <= 1'b0;
      shadowAmp <= SAFE_AMP;
      shadowPh  <= SAFE_PH;
    end else if (payValid) begin
      rspSeen <= ~drop;
      rspOk   <= accept;
      if (accept) begin
        shadowAmp <= rxAmp;
        shadowPh  <= payPh;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actAmp <= SAFE_AMP;
      actPh  <= SAFE_PH;
    end else if (rollback) begin
      actAmp <= SAFE_AMP;
      actPh  <= SAFE_PH;
    end else if (latchEn) begin
      actAmp <= shadowAmp;
      actPh  <= shadowPh;
    end
  end

  assign rbAmp = shadowAmp ^ AMP_W'(rbErr);
  assign rbPh  = shadowPh;

  // R2: active value moves only on latch or rollback
  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && !rollback) |=> ($stable(actAmp) && $stable(actPh)));

  // R4: latch copies shadow into active
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && !rollback) |=> (actAmp == $past(shadowAmp) && actPh == $past(shadowPh)));

  // R8: rollback lands on the safe profile
  p_rollback_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    rollback |=> (actAmp == SAFE_AMP && actPh == SAFE_PH));

endmodule

// File: rtl/wcControl.sv
module wcControl
  import wcPkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      chainOk,
  input  logic      cfgOk,
  output wcStrobe_t strobe,
  output logic      busy,
  output logic      latchPulse,
  output logic      abortPulse
);

  localparam int STREAK_W = $clog2(FAIL_LIMIT + 1);

  wcState_t state, stateNext;
  logic failQ;
  logic [STREAK_W-1:0] streak;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SEND;
      ST_SEND:   stateNext = ST_CHECK;
      ST_CHECK:  stateNext = (cfgOk && chainOk) ? ST_COMMIT : ST_ABORT;
      ST_COMMIT: stateNext = ST_IDLE;
      ST_ABORT:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      failQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_CHECK) failQ <= cfgOk & ~chainOk;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.send     = (state == ST_SEND);
    strobe.commit   = (state == ST_COMMIT);
    strobe.abort    = (state == ST_ABORT);
    strobe.failEvt  = (state == ST_ABORT) && failQ;
    strobe.rollback = strobe.failEvt && (streak == STREAK_W'(FAIL_LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streak <= '0;
    end else if (strobe.commit || strobe.rollback) begin
      streak <= '0;
    end else if (strobe.failEvt) begin
      streak <= streak + 1'b1;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign latchPulse = strobe.commit;
  assign abortPulse = strobe.abort;

  // R3: a transaction begins only from a host start
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R8: failure run never reaches the limit without a rollback
  p_streak_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    streak < STREAK_W'(FAIL_LIMIT));

endmodule

// File: rtl/wcDatapath.sv
module wcDatapath
  import wcPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMP_W = 6,
  parameter int PH_W = 6,
  parameter int SEQ_W = 8,
  parameter int VER_W = 8,
  parameter int CNT_W = 8,
  parameter int CHID_W = 8,
  parameter int CH_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wcStrobe_t               strobe,
  input  logic                    busy,
  input  logic                    stageWe,
  input  logic [CH_W-1:0]         stageCh,
  input  logic [AMP_W-1:0]        stageAmp,
  input  logic [PH_W-1:0]         stagePh,
  input  logic [NUM_CH-1:0]       chMask,
  input  logic [VER_W-1:0]        tableVer,
  input  logic [NUM_CH-1:0]       rspSeen,
  input  logic [NUM_CH-1:0]       rspOk,
  input  logic [NUM_CH*AMP_W-1:0] rbAmp,
  input  logic [NUM_CH*PH_W-1:0]  rbPh,
  output logic [NUM_CH-1:0]       payValid,
  output logic [SEQ_W-1:0]        paySeq,
  output logic [NUM_CH*AMP_W-1:0] payAmp,
  output logic [NUM_CH*PH_W-1:0]  payPh,
  output logic [NUM_CH*8-1:0]     payCrc,
  output logic [NUM_CH-1:0]       latchEn,
  output logic                    chainOk,
  output logic                    cfgOk,
  output logic [CNT_W-1:0]        failCnt,
  output logic [CNT_W-1:0]        skipCnt,
  output logic [CNT_W-1:0]        rollCnt
);

  localparam int MSG_W = CHID_W + SEQ_W + AMP_W + PH_W;

  logic [NUM_CH*AMP_W-1:0] stAmp;
  logic [NUM_CH*PH_W-1:0]  stPh;
  logic [NUM_CH-1:0]       maskQ;
  logic                    verOkQ;
  logic [SEQ_W-1:0]        seqQ;
  logic [NUM_CH-1:0]       chOk;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : gChan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stAmp[gi*AMP_W +: AMP_W] <= '0;
          stPh[gi*PH_W +: PH_W]    <= '0;
        end else if (stageWe && !busy && stageCh == CH_W'(gi)) begin
          stAmp[gi*AMP_W +: AMP_W] <= stageAmp;
          stPh[gi*PH_W +: PH_W]    <= stagePh;
        end
      end

      assign payCrc[gi*8 +: 8] = crc8Msg(CRC_MSG_MAX'({CHID_W'(gi), seqQ,
                                   stAmp[gi*AMP_W +: AMP_W], stPh[gi*PH_W +: PH_W]}), MSG_W);
      assign payValid[gi] = strobe.send & maskQ[gi];
      assign latchEn[gi]  = strobe.commit & maskQ[gi];
      assign chOk[gi] = ~maskQ[gi] |
                        (rspSeen[gi] & rspOk[gi] &
                         (rbAmp[gi*AMP_W +: AMP_W] == stAmp[gi*AMP_W +: AMP_W]) &
                         (rbPh[gi*PH_W +: PH_W] == stPh[gi*PH_W +: PH_W]));
    end
  endgenerate

  assign payAmp  = stAmp;
  assign payPh   = stPh;
  assign paySeq  = seqQ;
  assign chainOk = &chOk;
  assign cfgOk   = verOkQ & (|maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      verOkQ <= 1'b0;
      seqQ   <= '0;
    end else if (strobe.capture) begin
      maskQ  <= chMask;
      verOkQ <= (tableVer != '0);
      seqQ   <= seqQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
      skipCnt <= '0;
      rollCnt <= '0;
    end else begin
      if (strobe.abort && skipCnt != '1) skipCnt <= skipCnt + 1'b1;
      if (strobe.failEvt && failCnt != '1) failCnt <= failCnt + 1'b1;
      if (strobe.rollback && rollCnt != '1) rollCnt <= rollCnt + 1'b1;
    end
  end

  // R2: staged words are frozen during a transaction
  p_stage_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(stAmp) && $stable(stPh)));

  // R5: latch strobe only with every targeted check passing
  p_commit_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (chainOk && cfgOk));

  // R7: counters hold once saturated
  p_fail_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failCnt == '1) |=> (failCnt == '1));
  p_roll_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rollCnt == '1) |=> (rollCnt == '1));

endmodule

// File: rtl/weightCommitter.sv
module weightCommitter
  import wcPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AMP_W = 6,
  parameter int PH_W = 6,
  parameter int SEQ_W = 8,
  parameter int VER_W = 8,
  parameter int CNT_W = 8,
  parameter int CHID_W = 8,
  parameter int FAIL_LIMIT = 3,
  parameter logic [AMP_W-1:0] SAFE_AMP = '0,
  parameter logic [PH_W-1:0] SAFE_PH = '0,
  parameter int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stageWe,
  input  logic [CH_W-1:0]         stageCh,
  input  logic [AMP_W-1:0]        stageAmp,
  input  logic [PH_W-1:0]         stagePh,
  input  logic [NUM_CH-1:0]       chMask,
  input  logic [VER_W-1:0]        tableVer,
  input  logic                    start,
  input  logic [NUM_CH-1:0]       epDrop,
  input  logic [NUM_CH-1:0]       epCorrupt,
  input  logic [NUM_CH-1:0]       epRbErr,
  output logic                    busy,
  output logic                    latchPulse,
  output logic                    abortPulse,
  output logic [SEQ_W-1:0]        seqId,
  output logic [NUM_CH*AMP_W-1:0] activeAmp,
  output logic [NUM_CH*PH_W-1:0]  activePh,
  output logic [CNT_W-1:0]        failCnt,
  output logic [CNT_W-1:0]        skipCnt,
  output logic [CNT_W-1:0]        rollCnt
);

  wcStrobe_t               strobe;
  logic                    chainOk;
  logic                    cfgOk;
  logic [NUM_CH-1:0]       payValid;
  logic [SEQ_W-1:0]        paySeq;
  logic [NUM_CH*AMP_W-1:0] payAmp;
  logic [NUM_CH*PH_W-1:0]  payPh;
  logic [NUM_CH*8-1:0]     payCrc;
  logic [NUM_CH-1:0]       latchEn;
  logic [NUM_CH-1:0]       rspSeen;
  logic [NUM_CH-1:0]       rspOk;
  logic [NUM_CH*AMP_W-1:0] rbAmp;
  logic [NUM_CH*PH_W-1:0]  rbPh;

  wcControl #(.FAIL_LIMIT(FAIL_LIMIT)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .chainOk(chainOk), .cfgOk(cfgOk),
    .strobe(strobe), .busy(busy), .latchPulse(latchPulse), .abortPulse(abortPulse)
  );

  wcDatapath #(
    .NUM_CH(NUM_CH), .AMP_W(AMP_W), .PH_W(PH_W), .SEQ_W(SEQ_W), .VER_W(VER_W),
    .CNT_W(CNT_W), .CHID_W(CHID_W), .CH_W(CH_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .stageWe(stageWe), .stageCh(stageCh), .stageAmp(stageAmp), .stagePh(stagePh),
    .chMask(chMask), .tableVer(tableVer),
    .rspSeen(rspSeen), .rspOk(rspOk), .rbAmp(rbAmp), .rbPh(rbPh),
    .payValid(payValid), .paySeq(paySeq), .payAmp(payAmp), .payPh(payPh), .payCrc(payCrc),
    .latchEn(latchEn), .chainOk(chainOk), .cfgOk(cfgOk),
    .failCnt(failCnt), .skipCnt(skipCnt), .rollCnt(rollCnt)
  );

  assign seqId = paySeq;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : gEp
      wcEndpoint #(
        .CH_ID(gi), .AMP_W(AMP_W), .PH_W(PH_W), .SEQ_W(SEQ_W), .CHID_W(CHID_W),
        .SAFE_AMP(SAFE_AMP), .SAFE_PH(SAFE_PH)
      ) uEp (
        .clk(clk), .rstN(rstN), .txnBegin(strobe.capture),
        .payValid(payValid[gi]), .paySeq(paySeq),
        .payAmp(payAmp[gi*AMP_W +: AMP_W]), .payPh(payPh[gi*PH_W +: PH_W]),
        .payCrc(payCrc[gi*8 +: 8]),
        .drop(epDrop[gi]), .corrupt(epCorrupt[gi]), .rbErr(epRbErr[gi]),
        .latchEn(latchEn[gi]), .rollback(strobe.rollback),
        .rspSeen(rspSeen[gi]), .rspOk(rspOk[gi]),
        .rbAmp(rbAmp[gi*AMP_W +: AMP_W]), .rbPh(rbPh[gi*PH_W +: PH_W]),
        .actAmp(activeAmp[gi*AMP_W +: AMP_W]), .actPh(activePh[gi*PH_W +: PH_W])
      );
    end
  endgenerate

endmodule

// File: tb/weightCommitter_test.sv
module weightCommitter_test;

  localparam int NCH = 4;
  localparam int AW = 6;
  localparam int PW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rstN;
  logic            stageWe;
  logic [1:0]      stageCh;
  logic [AW-1:0]   stageAmp;
  logic [PW-1:0]   stagePh;
  logic [NCH-1:0]  chMask;
  logic [7:0]      tableVer;
  logic            start;
  logic [NCH-1:0]  epDrop, epCorrupt, epRbErr;
  logic            busy, latchPulse, abortPulse;
  logic [7:0]      seqId;
  logic [NCH*AW-1:0] activeAmp;
  logic [NCH*PW-1:0] activePh;
  logic [7:0]      failCnt, skipCnt, rollCnt;

  weightCommitter uut (
    .clk(clk), .rstN(rstN), .stageWe(stageWe), .stageCh(stageCh), .stageAmp(stageAmp),
    .stagePh(stagePh), .chMask(chMask), .tableVer(tableVer), .start(start),
    .epDrop(epDrop), .epCorrupt(epCorrupt), .epRbErr(epRbErr),
    .busy(busy), .latchPulse(latchPulse), .abortPulse(abortPulse), .seqId(seqId),
    .activeAmp(activeAmp), .activePh(activePh),
    .failCnt(failCnt), .skipCnt(skipCnt), .rollCnt(rollCnt)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mPh, mSeq, mMask, mConsec, mFailC, mSkipC, mRollC;
  bit mVer, mFailQ;
  int mStA[NCH], mStP[NCH], mActA[NCH], mActP[NCH];

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mSeq = 0; mMask = 0; mConsec = 0; mFailC = 0; mSkipC = 0; mRollC = 0;
      mVer = 0; mFailQ = 0;
      for (int c = 0; c < NCH; c++) begin mStA[c] = 0; mStP[c] = 0; mActA[c] = 0; mActP[c] = 0; end
    end else begin
      case (mPh)
        0: begin
          if (stageWe) begin mStA[stageCh] = stageAmp; mStP[stageCh] = stagePh; end
          if (start) begin
            mPh = 1; mSeq = (mSeq + 1) % 256; mMask = chMask; mVer = (tableVer != 0);
          end
        end
        1: mPh = 2;
        2: begin
          bit cfg, ok;
          cfg = mVer && (mMask != 0);
          ok = (((epDrop | epCorrupt | epRbErr) & mMask[NCH-1:0]) == 0);
          if (cfg && ok) mPh = 3;
          else begin mPh = 4; mFailQ = cfg; end
        end
        3: begin
          for (int c = 0; c < NCH; c++) if (mMask[c]) begin mActA[c] = mStA[c]; mActP[c] = mStP[c]; end
          mConsec = 0; mPh = 0;
        end
        default: begin
          if (mSkipC < 255) mSkipC++;
          if (mFailQ) begin
            if (mFailC < 255) mFailC++;
            mConsec++;
            if (mConsec == 3) begin
              if (mRollC < 255) mRollC++;
              mConsec = 0;
              for (int c = 0; c < NCH; c++) begin mActA[c] = 0; mActP[c] = 0; end
            end
          end
          mPh = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NCH; c++) begin
        check("R4", "model activeAmp", 64'(activeAmp[c*AW +: AW]), 64'(mActA[c]));
        check("R4", "model activePh", 64'(activePh[c*PW +: PW]), 64'(mActP[c]));
      end
      check("R3", "model busy", 64'(busy), 64'(mPh != 0));
      check("R3", "model latchPulse", 64'(latchPulse), 64'(mPh == 3));
      check("R5", "model abortPulse", 64'(abortPulse), 64'(mPh == 4));
      check("R3", "model seqId", 64'(seqId), 64'(mSeq));
      check("R7", "model failCnt", 64'(failCnt), 64'(mFailC));
      check("R7", "model skipCnt", 64'(skipCnt), 64'(mSkipC));
      check("R7", "model rollCnt", 64'(rollCnt), 64'(mRollC));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic stage(input int ch, input int a, input int p);
    stageWe = 1; stageCh = 2'(ch); stageAmp = AW'(a); stagePh = PW'(p);
    @(negedge clk);
    stageWe = 0;
  endtask

  task automatic runTxn(input logic [3:0] mask, input logic [7:0] ver, input logic [3:0] drp,
                        input logic [3:0] cor, input logic [3:0] rbe, input bit holdStart,
                        input int lateCh, input int lateA, input int lateP);
    chMask = mask; tableVer = ver; epDrop = drp; epCorrupt = cor; epRbErr = rbe; start = 1;
    @(negedge clk);
    if (!holdStart) start = 0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    if (lateCh >= 0) begin
      stageWe = 1; stageCh = 2'(lateCh); stageAmp = AW'(lateA); stagePh = PW'(lateP);
    end
    @(negedge clk);
    stageWe = 0; epDrop = 0; epCorrupt = 0; epRbErr = 0;
  endtask

  function automatic int aOf(input int c); return int'(activeAmp[c*AW +: AW]); endfunction
  function automatic int pOf(input int c); return int'(activePh[c*PW +: PW]); endfunction

  initial begin
    rstN = 0; stageWe = 0; stageCh = 0; stageAmp = 0; stagePh = 0; chMask = 0; tableVer = 0;
    start = 0; epDrop = 0; epCorrupt = 0; epRbErr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "activeAmp", 64'(activeAmp), 0);
    check("R1", "activePh", 64'(activePh), 0);
    check("R1", "counters", 64'({failCnt, skipCnt, rollCnt, seqId}), 0);
    check("R1", "pulses", 64'({busy, latchPulse, abortPulse}), 0);
    rstN = 1;
    @(negedge clk);

    // R2 staging alone changes nothing active
    for (int c = 0; c < NCH; c++) stage(c, 10 + c, 20 + c);
    check("R2", "active after staging", 64'({activeAmp, activePh}), 0);

    // R3, R4 full commit; busy timing probed inside
    chMask = 4'hF; tableVer = 8'd1; start = 1;
    @(negedge clk); start = 0;
    check("R3", "busy first cycle", 64'(busy), 1);
    @(negedge clk);
    check("R3", "no latch second cycle", 64'(latchPulse), 0);
    @(negedge clk);
    check("R3", "latch third cycle", 64'({latchPulse, abortPulse}), 64'(2));
    @(negedge clk);
    check("R3", "busy released", 64'(busy), 0);
    check("R3", "seq after first", 64'(seqId), 1);
    for (int c = 0; c < NCH; c++) begin
      check("R4", "commit amp", 64'(aOf(c)), 64'(10 + c));
      check("R4", "commit ph", 64'(pOf(c)), 64'(20 + c));
    end

    // R4, R10 partial mask, fault on untargeted channel 3
    stage(1, 33, 44); stage(2, 35, 46);
    runTxn(4'b0010, 8'd2, 4'b1000, 4'b0100, 4'b0000, 0, -1, 0, 0);
    check("R10", "untargeted fault ignored", 64'({aOf(1), pOf(1)}), 64'({32'd33, 32'd44}));
    check("R4", "unmasked channel held", 64'({aOf(2), pOf(2)}), 64'({32'd12, 32'd22}));

    // R5 faults: no response, corrupted payload, readback mismatch
    stage(0, 50, 60);
    runTxn(4'hF, 8'd3, 4'b0001, 4'b0000, 4'b0000, 0, -1, 0, 0);
    check("R5", "drop keeps ch0", 64'({aOf(0), pOf(0)}), 64'({32'd10, 32'd20}));
    check("R5", "drop keeps ch2", 64'(aOf(2)), 12);
    runTxn(4'hF, 8'd3, 4'b0000, 4'b0100, 4'b0000, 0, -1, 0, 0);
    check("R5", "corrupt keeps ch0", 64'(aOf(0)), 10);
    runTxn(4'hF, 8'd3, 0, 0, 0, 0, -1, 0, 0);
    check("R4", "recommit ch0", 64'({aOf(0), pOf(0)}), 64'({32'd50, 32'd60}));
    check("R4", "recommit ch2", 64'({aOf(2), pOf(2)}), 64'({32'd35, 32'd46}));
    stage(1, 1, 2);
    runTxn(4'hF, 8'd3, 0, 0, 4'b0010, 0, -1, 0, 0);
    check("R5", "readback keeps ch1", 64'({aOf(1), pOf(1)}), 64'({32'd33, 32'd44}));
    check("R5", "fail count", 64'(failCnt), 3);

    // R6 skips without failure count
    runTxn(4'hF, 8'd0, 0, 0, 0, 0, -1, 0, 0);
    runTxn(4'h0, 8'd5, 0, 0, 0, 0, -1, 0, 0);
    check("R6", "skip count", 64'(skipCnt), 5);
    check("R6", "fail count unchanged", 64'(failCnt), 3);
    check("R6", "active unchanged", 64'(aOf(0)), 50);

    // R8 third consecutive validation failure rolls back
    runTxn(4'hF, 8'd4, 4'b0100, 0, 0, 0, -1, 0, 0);
    check("R8", "no rollback yet", 64'(rollCnt), 0);
    runTxn(4'hF, 8'd4, 0, 4'b1000, 0, 0, -1, 0, 0);
    check("R8", "rollback count", 64'(rollCnt), 1);
    check("R8", "safe amp", 64'(activeAmp), 0);
    check("R8", "safe ph", 64'(activePh), 0);

    // R9, R2 held start and stage write during the latch cycle
    stage(3, 7, 9);
    runTxn(4'b1000, 8'd6, 0, 0, 0, 1, 3, 63, 63);
    check("R9", "seq single step", 64'(seqId), 11);
    check("R9", "busy ended", 64'(busy), 0);
    check("R2", "late write not latched", 64'({aOf(3), pOf(3)}), 64'({32'd7, 32'd9}));
    runTxn(4'b1000, 8'd6, 0, 0, 0, 0, -1, 0, 0);
    check("R2", "late write discarded", 64'({aOf(3), pOf(3)}), 64'({32'd7, 32'd9}));

    // R7 saturation of every counter
    for (int k = 0; k < 800; k++) runTxn(4'b0001, 8'd9, 4'b0001, 0, 0, 0, -1, 0, 0);
    check("R7", "failCnt saturated", 64'(failCnt), 255);
    check("R7", "skipCnt saturated", 64'(skipCnt), 255);
    check("R7", "rollCnt saturated", 64'(rollCnt), 255);
    check("R8", "rolled back to safe", 64'(aOf(3)), 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule